// File: doc/BRIEF.md
# Successive-Approximation ADC Sequencer with APB Register Interface

This block sits between an APB bus and the analog half of a successive-approximation converter. It drives the DAC trial code, the input-multiplexer select and the converter power enable. It reads back a single comparator decision. Software picks an input channel, optionally enables the interrupt, and sets the power bit in one control write. The block then counts a programmable power-up settling time in converter clock periods. After that it resolves the result one bit per converter clock, most significant bit first.

When the search ends, the result goes into the data register, the interrupt flag is raised and busy is dropped. A driver reads the data register from its interrupt handler. It then writes zero to the control register, which acknowledges the interrupt and removes converter power in the same access.

The converter clock is a clock enable, one pulse every `CLK_DIV` bus clocks. The divider restarts on every accepted start, so conversion time is an exact number of bus clocks.

The sequencer is a four-state machine:
- `ST_IDLE` goes to `ST_POWERUP` on an accepted start with a nonzero delay, or straight to `ST_TRIAL` when the delay is zero.
- `ST_POWERUP` goes to `ST_TRIAL` on the converter tick that completes the delay.
- `ST_TRIAL` goes to `ST_DONE` on the tick that decides bit 0.
- `ST_DONE` returns to `ST_IDLE` after one bus clock, loading the result.

Top module: `sar_adc_ctrl`

## Requirements
- R1: After reset, the data, status and control registers read 0 and the delay register reads 8. `irq`, `adc_power` and `dac_code` are 0.
- R2: Register offsets are 0x00 data (read-only), 0x04 status, 0x08 control and 0x0C delay. The delay register keeps only bits [5:0]. Any other offset reads 0. `pready` is always 1.
- R3: In the control register, bits [2:0] are the channel, bit 3 is power/start, bit 5 is interrupt enable and bit 6 is the interrupt flag. A control write with bit 3 set, accepted while idle, starts a conversion. Status bit 0 (busy) then reads 1, `adc_power` is 1 and `chan_sel` equals the written channel.
- R4: With delay N and result width B, the interrupt flag rises exactly `CLK_DIV*(N+B)+1` bus clocks after the clock edge that accepts the start.
- R5: Bits are decided MSB first, one per converter tick. A trial bit is kept when `cmp_ge` is 1 (input at or above `dac_code`). The data register ends up holding the input code.
- R6: When a conversion ends, the data register is loaded with its upper bits zero, control bit 6 is set and busy drops.
- R7: `irq` is high exactly when the interrupt flag and interrupt enable are both 1.
- R8: Writing 0 to the control register while idle clears the interrupt flag, clears `adc_power`, and leaves the data register unchanged.
- R9: While busy, a control write leaves the channel, power and enable fields unchanged, and the conversion continues. A control write with bit 6 clear still clears the interrupt flag; one with bit 6 set leaves it.
- R10: A control write naming a channel at or above `NUM_CH` changes no field and starts nothing, apart from the bit-6 flag clear.
- R11: `dac_code` is 0 whenever the sequencer is not in its bit-trial phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pclk | input | 1 | Bus and sequencer clock |
| presetn | input | 1 | Active-low asynchronous reset |
| psel | input | 1 | APB select |
| penable | input | 1 | APB access phase |
| pwrite | input | 1 | APB write strobe |
| paddr | input | ADDR_W | APB byte address |
| pwdata | input | 32 | APB write data |
| prdata | output | 32 | APB read data |
| pready | output | 1 | APB ready, tied high |
| cmp_ge | input | 1 | Comparator: selected input at or above `dac_code` |
| dac_code | output | RES_BITS | Trial code for the DAC |
| chan_sel | output | 3 | Input multiplexer select |
| adc_power | output | 1 | Converter power enable |
| irq | output | 1 | Interrupt request |

## Verification
On every cycle the assertions check several invariants:
- busy keeps the converter powered and the channel select frozen;
- a conversion only starts on a legal channel;
- busy can only fall with the interrupt flag set;
- `irq` never rises without both flag and enable;
- the DAC code is idle outside the trial phase.

The exact conversion latency and the numeric correctness of the result can only be shown by the bench scenarios, which sweep every input code over the channels against a digital comparator model. The same holds for the masking of busy-time and illegal-channel writes, and for the single-write acknowledge.

// File: rtl/sar_adc_pkg.sv
package sar_adc_pkg;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_POWERUP = 2'd1,
        ST_TRIAL   = 2'd2,
        ST_DONE    = 2'd3
    } sar_state_e;

    localparam logic [3:0] OFS_DATA  = 4'h0;
    localparam logic [3:0] OFS_STAT  = 4'h4;
    localparam logic [3:0] OFS_CTRL  = 4'h8;
    localparam logic [3:0] OFS_DELAY = 4'hC;

    localparam int CH_W     = 3;
    localparam int CTL_PWR  = 3;
    localparam int CTL_IEN  = 5;
    localparam int CTL_FLAG = 6;
    localparam int DLY_W    = 6;

endpackage

// File: rtl/sar_adc_tick.sv
module sar_adc_tick #(
    parameter int CLK_DIV = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic run,
    output logic tick
);
    generate
        if (CLK_DIV <= 1) begin : g_full_rate
            assign tick = run;
        end else begin : g_divided
            localparam int CNT_W = $clog2(CLK_DIV);
            localparam logic [CNT_W-1:0] LAST = CNT_W'(CLK_DIV - 1);
            logic [CNT_W-1:0] cnt_q;

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    cnt_q <= '0;
                end else if (clear) begin
                    cnt_q <= '0;
                end else if (run) begin
                    cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
                end
            end

            assign tick = run && (cnt_q == LAST);
        end
    endgenerate
endmodule

// File: rtl/sar_adc_seq.sv
module sar_adc_seq
    import sar_adc_pkg::*;
#(
    parameter int RES_BITS = 10
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start,
    input  logic [DLY_W-1:0]    dly,
    input  logic                tick,
    input  logic                cmp_ge,
    output logic                busy,
    output logic                done,
    output logic [RES_BITS-1:0] dac_code,
    output logic [RES_BITS-1:0] result
);
    localparam logic [RES_BITS-1:0] MSB_BIT = {1'b1, {(RES_BITS-1){1'b0}}};
    localparam logic [DLY_W-1:0]    DLY_ONE = DLY_W'(1);

    sar_state_e state_q, state_d;
    logic [DLY_W-1:0]    cnt_q;
    logic [RES_BITS-1:0] acc_q;
    logic [RES_BITS-1:0] trial_q;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (start) state_d = (dly == '0) ? ST_TRIAL : ST_POWERUP;
            end
            ST_POWERUP: begin
                if (tick && cnt_q == DLY_ONE) state_d = ST_TRIAL;
            end
            ST_TRIAL: begin
                if (tick && trial_q[0]) state_d = ST_DONE;
            end
            ST_DONE: begin
                state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q   <= '0;
            acc_q   <= '0;
            trial_q <= '0;
        end else begin
            if (state_q == ST_IDLE && start) begin
                cnt_q   <= dly;
                acc_q   <= '0;
                trial_q <= MSB_BIT;
            end else if (state_q == ST_POWERUP && tick) begin
                cnt_q <= cnt_q - 1'b1;
            end else if (state_q == ST_TRIAL && tick) begin
                if (cmp_ge) acc_q <= acc_q | trial_q;
                trial_q <= trial_q >> 1;
            end
        end
    end

    always_comb begin
        busy     = (state_q != ST_IDLE);
        done     = (state_q == ST_DONE);
        dac_code = (state_q == ST_TRIAL) ? (acc_q | trial_q) : '0;
        result   = acc_q;
    end
endmodule

// File: rtl/sar_adc_regs.sv
module sar_adc_regs
    import sar_adc_pkg::*;
#(
    parameter int RES_BITS = 10,
    parameter int NUM_CH   = 3,
    parameter int ADDR_W   = 8,
    parameter int DLY_RST  = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                psel,
    input  logic                penable,
    input  logic                pwrite,
    input  logic [ADDR_W-1:0]   paddr,
    input  logic [31:0]         pwdata,
    output logic [31:0]         prdata,
    input  logic                busy,
    input  logic                done,
    input  logic [RES_BITS-1:0] result,
    output logic [CH_W-1:0]     chan,
    output logic                power,
    output logic                irq_en,
    output logic                irq_flag,
    output logic [DLY_W-1:0]    dly,
    output logic                start
);
    localparam logic [CH_W:0] CH_LIMIT = NUM_CH[CH_W:0];

    logic [RES_BITS-1:0] data_q;
    logic                wr_en, ctl_wr, dly_wr, chan_ok, accept;
    logic                unused_bits;

    assign unused_bits = ^pwdata[31:7];

    assign wr_en   = psel && penable && pwrite;
    assign ctl_wr  = wr_en && (paddr == ADDR_W'(OFS_CTRL));
    assign dly_wr  = wr_en && (paddr == ADDR_W'(OFS_DELAY));
    assign chan_ok = ({1'b0, pwdata[CH_W-1:0]} < CH_LIMIT);
    assign accept  = ctl_wr && !busy && chan_ok;
    assign start   = accept && pwdata[CTL_PWR];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chan     <= '0;
            power    <= 1'b0;
            irq_en   <= 1'b0;
            irq_flag <= 1'b0;
            dly      <= DLY_W'(DLY_RST);
            data_q   <= '0;
        end else begin
            if (dly_wr) dly <= pwdata[DLY_W-1:0];
            if (accept) begin
                chan   <= pwdata[CH_W-1:0];
                power  <= pwdata[CTL_PWR];
                irq_en <= pwdata[CTL_IEN];
            end
            if (done)                             irq_flag <= 1'b1;
            else if (ctl_wr && !pwdata[CTL_FLAG]) irq_flag <= 1'b0;
            if (done) data_q <= result;
        end
    end

    always_comb begin
        prdata = '0;
        if (psel && !pwrite) begin
            unique case (paddr)
                ADDR_W'(OFS_DATA):  prdata = 32'(data_q);
                ADDR_W'(OFS_STAT):  prdata = 32'(busy);
                ADDR_W'(OFS_CTRL):  prdata = 32'({irq_flag, irq_en, 1'b0, power, chan});
                ADDR_W'(OFS_DELAY): prdata = 32'(dly);
                default:            prdata = '0;
            endcase
        end
    end
endmodule

// File: rtl/sar_adc_ctrl.sv
module sar_adc_ctrl
    import sar_adc_pkg::*;
#(
    parameter int RES_BITS = 10,
    parameter int NUM_CH   = 3,
    parameter int CLK_DIV  = 4,
    parameter int ADDR_W   = 8
) (
    input  logic                pclk,
    input  logic                presetn,
    input  logic                psel,
    input  logic                penable,
    input  logic                pwrite,
    input  logic [ADDR_W-1:0]   paddr,
    input  logic [31:0]         pwdata,
    output logic [31:0]         prdata,
    output logic                pready,
    input  logic                cmp_ge,
    output logic [RES_BITS-1:0] dac_code,
    output logic [2:0]          chan_sel,
    output logic                adc_power,
    output logic                irq
);
    logic                busy, done, start, tick;
    logic                irq_en, irq_flag;
    logic [DLY_W-1:0]    dly;
    logic [RES_BITS-1:0] result;

    sar_adc_regs #(
        .RES_BITS(RES_BITS), .NUM_CH(NUM_CH), .ADDR_W(ADDR_W), .DLY_RST(8)
    ) u_regs (
        .clk(pclk), .rst_n(presetn),
        .psel(psel), .penable(penable), .pwrite(pwrite),
        .paddr(paddr), .pwdata(pwdata), .prdata(prdata),
        .busy(busy), .done(done), .result(result),
        .chan(chan_sel), .power(adc_power),
        .irq_en(irq_en), .irq_flag(irq_flag),
        .dly(dly), .start(start)
    );

    sar_adc_tick #(.CLK_DIV(CLK_DIV)) u_tick (
        .clk(pclk), .rst_n(presetn),
        .clear(start), .run(busy), .tick(tick)
    );

    sar_adc_seq #(.RES_BITS(RES_BITS)) u_seq (
        .clk(pclk), .rst_n(presetn),
        .start(start), .dly(dly), .tick(tick), .cmp_ge(cmp_ge),
        .busy(busy), .done(done), .dac_code(dac_code), .result(result)
    );

    assign pready = 1'b1;
    assign irq    = irq_flag && irq_en;
endmodule

// File: rtl/sar_adc_ctrl_chk.sv
module sar_adc_ctrl_chk #(
    parameter int RES_BITS = 10,
    parameter int NUM_CH   = 3
) (
    input logic                clk,
    input logic                rst_n,
    input logic                busy,
    input logic                irq,
    input logic                irq_en,
    input logic                irq_flag,
    input logic                adc_power,
    input logic [2:0]          chan_sel,
    input logic [RES_BITS-1:0] dac_code
);
    localparam logic [3:0] CH_LIMIT = NUM_CH[3:0];

    AST_DONE_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> irq_flag); // R6
    AST_IDLE_DAC_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (dac_code == '0)); // R11
    AST_BUSY_POWERED: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> adc_power); // R9
    AST_BUSY_CHAN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(chan_sel)); // R9
    AST_START_LEGAL_CHAN: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> ({1'b0, chan_sel} < CH_LIMIT)); // R10
    AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_en |-> !irq); // R7
    AST_IRQ_NEEDS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> irq_flag); // R7
endmodule

bind sar_adc_ctrl sar_adc_ctrl_chk #(.RES_BITS(RES_BITS), .NUM_CH(NUM_CH)) u_chk (
    .clk(pclk), .rst_n(presetn), .busy(busy), .irq(irq),
    .irq_en(irq_en), .irq_flag(irq_flag), .adc_power(adc_power),
    .chan_sel(chan_sel), .dac_code(dac_code)
);

// File: tb/sar_adc_ctrl_test.sv
module sar_adc_ctrl_test;
    localparam int RES = 10;
    localparam int NCH = 3;
    localparam int DIV = 4;
    localparam logic [7:0] A_DATA = 8'h00, A_STAT = 8'h04, A_CTRL = 8'h08, A_DLY = 8'h0C;

    logic clk = 1'b0, rst_n = 1'b0;
    logic psel = 0, penable = 0, pwrite = 0;
    logic [7:0] paddr = '0;
    logic [31:0] pwdata = '0, prdata;
    logic pready, cmp_ge, adc_power, irq;
    logic [RES-1:0] dac_code;
    logic [2:0] chan_sel;
    logic [RES-1:0] vin [8];

    int n_tests = 0, n_fail = 0;
    bit finished = 0;

    always #10 clk = ~clk;

    assign cmp_ge = (vin[chan_sel] >= dac_code);

    sar_adc_ctrl #(.RES_BITS(RES), .NUM_CH(NCH), .CLK_DIV(DIV), .ADDR_W(8)) uut (
        .pclk(clk), .presetn(rst_n), .psel(psel), .penable(penable), .pwrite(pwrite),
        .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .pready(pready),
        .cmp_ge(cmp_ge), .dac_code(dac_code), .chan_sel(chan_sel),
        .adc_power(adc_power), .irq(irq)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic apb_wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk); psel = 1; pwrite = 1; paddr = a; pwdata = d; penable = 0;
        @(negedge clk); penable = 1;
        @(negedge clk); psel = 0; penable = 0; pwrite = 0;
    endtask

    task automatic apb_rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk); psel = 1; pwrite = 0; paddr = a; penable = 0;
        @(negedge clk); penable = 1; d = prdata;
        @(negedge clk); psel = 0; penable = 0;
    endtask

    task automatic wait_irq(output int c);
        c = 0;
        while (!irq && c < 5000) begin @(negedge clk); c++; end
    endtask

    task automatic wait_idle();
        logic [31:0] s;
        s = 1;
        for (int k = 0; k < 500 && s[0]; k++) apb_rd(A_STAT, s);
    endtask

    initial begin
        logic [31:0] rd;
        int lat;
        for (int i = 0; i < 8; i++) vin[i] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        chk("R1 irq", 32'(irq), 0);
        chk("R1 adc_power", 32'(adc_power), 0);
        chk("R1 dac_code", 32'(dac_code), 0);
        apb_rd(A_DATA, rd); chk("R1 data", rd, 0);
        apb_rd(A_STAT, rd); chk("R1 status", rd, 0);
        apb_rd(A_CTRL, rd); chk("R1 ctrl", rd, 0);
        apb_rd(A_DLY, rd);  chk("R1 delay", rd, 8);

        // R2 map, masking, pready
        chk("R2 pready", 32'(pready), 1);
        apb_wr(A_DLY, 32'hFFFF_FF7F); apb_rd(A_DLY, rd); chk("R2 delay mask", rd, 32'h3F);
        apb_rd(8'h10, rd); chk("R2 unmapped", rd, 0);
        apb_wr(A_DATA, 32'h155); apb_rd(A_DATA, rd); chk("R2 data read-only", rd, 0);

        // R3 R4 R5 R6 R7: delay 3, channel 1, irq enabled
        vin[0] = 10'h0F0; vin[1] = 10'h2A5; vin[2] = 10'h111;
        apb_wr(A_DLY, 3);
        apb_wr(A_CTRL, 32'h28 | 1);
        chk("R3 power", 32'(adc_power), 1);
        chk("R3 chan_sel", 32'(chan_sel), 1);
        chk("R11 dac idle in powerup", 32'(dac_code), 0);
        wait_irq(lat);
        chk("R4 latency dly3", lat, DIV * (3 + RES) + 1);
        chk("R7 irq", 32'(irq), 1);
        apb_rd(A_DATA, rd); chk("R5 data ch1", rd, 32'h2A5);
        apb_rd(A_CTRL, rd); chk("R6 ctrl flag", rd, 32'h69);
        apb_rd(A_STAT, rd); chk("R6 busy low", rd, 0);
        chk("R11 dac idle after", 32'(dac_code), 0);

        // R8 single zero write
        apb_wr(A_CTRL, 0);
        chk("R8 irq cleared", 32'(irq), 0);
        chk("R8 power off", 32'(adc_power), 0);
        apb_rd(A_CTRL, rd); chk("R8 ctrl", rd, 0);
        apb_rd(A_DATA, rd); chk("R8 data kept", rd, 32'h2A5);

        // R9 writes during busy, irq disabled
        apb_wr(A_DLY, 2);
        vin[2] = 10'h123;
        apb_wr(A_CTRL, 32'h08 | 2);
        chk("R3 status busy", 32'(adc_power), 1);
        apb_rd(A_STAT, rd); chk("R3 busy bit", rd, 1);
        apb_wr(A_CTRL, 0);
        chk("R9 power held", 32'(adc_power), 1);
        apb_wr(A_CTRL, 32'h28 | 1);
        chk("R9 chan held", 32'(chan_sel), 2);
        wait_idle();
        chk("R7 irq masked", 32'(irq), 0);
        apb_rd(A_CTRL, rd); chk("R9 ctrl after busy writes", rd, 32'h4A);
        apb_rd(A_DATA, rd); chk("R5 data ch2", rd, 32'h123);

        vin[1] = 10'h3FF;
        apb_wr(A_CTRL, 32'h48 | 1);
        apb_rd(A_CTRL, rd); chk("R9 flag kept by bit6", rd, 32'h49);
        apb_wr(A_CTRL, 0);
        apb_rd(A_CTRL, rd); chk("R9 flag cleared while busy", rd, 32'h09);
        wait_idle();
        apb_rd(A_CTRL, rd); chk("R6 flag set again", rd, 32'h49);
        apb_rd(A_DATA, rd); chk("R5 data max code", rd, 32'h3FF);
        apb_wr(A_CTRL, 0);

        // R10 illegal channels
        apb_wr(A_CTRL, 32'h28 | 3);
        chk("R10 no power ch3", 32'(adc_power), 0);
        apb_rd(A_STAT, rd); chk("R10 not busy ch3", rd, 0);
        apb_rd(A_CTRL, rd); chk("R10 ctrl unchanged ch3", rd, 0);
        apb_wr(A_CTRL, 32'h2F);
        chk("R10 no power ch7", 32'(adc_power), 0);
        apb_rd(A_CTRL, rd); chk("R10 ctrl unchanged ch7", rd, 0);

        // R4 maximum delay, code 0
        vin[0] = 0;
        apb_wr(A_DLY, 63);
        apb_wr(A_CTRL, 32'h28);
        wait_irq(lat);
        chk("R4 latency dly63", lat, DIV * (63 + RES) + 1);
        apb_rd(A_DATA, rd); chk("R5 data zero", rd, 0);
        apb_wr(A_CTRL, 0);

        // R5 R4 sweep of every code across channels, delay 0
        apb_wr(A_DLY, 0);
        for (int code = 0; code < (1 << RES); code++) begin
            int ch;
            ch = code % NCH;
            for (int j = 0; j < NCH; j++) vin[j] = RES'(~code);
            vin[ch] = RES'(code);
            apb_wr(A_CTRL, 32'h28 | ch);
            wait_irq(lat);
            chk("R4 latency dly0", lat, DIV * RES + 1);
            apb_rd(A_DATA, rd);
            chk("R5 sweep data", rd, 32'(code));
            apb_wr(A_CTRL, 0);
        end

        finished = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule